// File: doc/BRIEF.md
# Multichannel Phase-Shifted Reference Generator

This block generates a set of square-wave reference signals for a multi-channel transmitter, one per antenna path. Each reference is a copy of a common square wave that is delayed by a programmable whole number of clock cycles. The references then feed integer phase-locked loops. One free-running counter of `K` bits steps by one on every clock. Each channel compares that count against its own phase word. The output period is therefore `2^K` clocks, and the delay resolution is one clock, which is 360/2^K degrees of the output period, at every setting.

Software or a beam controller presents new delays for all channels on a flat bus together with a one-cycle load strobe. The block holds the loaded values and applies them only at the point where the shared count returns to zero. Every channel therefore changes delay on the same cycle, at a period boundary. All outputs, including an undelayed reference, leave the block through a flip-flop, so they share one cycle of latency from the count.

Top module: `phref_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the count, the held words and the applied words clear to zero, and after that edge `ref_out` and every bit of `chan_out` are 0.
- R2: `ref_out` repeats every 2^K clocks. After reset is released it is high for the first 2^(K-1) clocks of each period, starting with the clock that follows the first edge with `rst_n` high, and low for the remaining 2^(K-1).
- R3: Channel `c` is high exactly when (count − w_c) mod 2^K < 2^(K-1), where w_c is the applied word of that channel, and it is registered like `ref_out`. The duty cycle is therefore 50%.
- R4: With the applied word steady, the rising edge of channel `c` follows the rising edge of `ref_out` by exactly w_c clocks, for every code from 0 to 2^K−1. A word of 0 gives an output identical to `ref_out`.
- R5: A clock edge with `word_load` high copies the whole of `phase_words` into the held words. Channel `c` takes bits [c*K +: K]. The applied words change only at the edge where the count goes from 2^K−1 to 0. Until then the outputs keep following the previous words. If several loads fall within one period, the last one wins.
- R6: If `word_load` is high at the edge where the count wraps to zero, the words presented on that edge are applied at that same wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| word_load | input | 1 | Strobe that captures `phase_words` on this edge |
| phase_words | input | NCH*K | Delay words, channel c in bits [c*K +: K] |
| ref_out | output | 1 | Undelayed square-wave reference |
| chan_out | output | NCH | Delayed square-wave outputs, bit c for channel c |

## Verification
The load strobe and the count wrap can fall on the same clock edge. That edge is the boundary between the deferral in R5 and the immediate application in R6. The bench waits until the count is at its maximum value and raises the strobe for exactly that edge. It also loads on the first cycle after a wrap, and it issues two loads within one period. A behavioural model of the held and applied words predicts every output on every clock, and it decides which words are in force in each of these cases. Rising-edge offsets are measured against `ref_out` once the words have been steady for two periods.

// File: rtl/phref_pkg.sv
// Package: shared defaults for the phase-shifted reference generator.
// Assumes nothing; holds only the default counter width and channel count.
package phref_pkg;
    localparam int unsigned PHREF_K_DEFAULT  = 4;  // count width, phase step 360/2^K
    localparam int unsigned PHREF_CH_DEFAULT = 4;  // number of delayed channels
endpackage

// File: rtl/phref_timebase.sv
// Module: phref_timebase
// Shared time base. A K-bit count steps by one every clock and wraps
// naturally. It flags the wrap cycle and drives the registered, undelayed
// reference square wave (high during the first half of the count).
// Assumes K >= 2.
module phref_timebase #(
    parameter int unsigned K = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [K-1:0] cnt_o,
    output logic         wrap_o,
    output logic         ref_o
);
    localparam logic [K-1:0] CNT_TOP = '1;
    localparam logic [K-1:0] HALF    = K'(1) << (K - 1);

    logic [K-1:0] cnt_q;
    logic         ref_q;
    logic         armed_q;

    // Free-running count with a fixed step of one.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    // Registered reference: high while the count is in its first half.
    always_ff @(posedge clk) begin
        if (!rst_n) ref_q <= 1'b0;
        else        ref_q <= (cnt_q < HALF);
    end

    // Marks that at least one edge has run out of reset (checks only).
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = (cnt_q == CNT_TOP);
    assign ref_o  = ref_q;

    // R2: the count advances by exactly one each clock
    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (cnt_q == K'($past(cnt_q) + 1'b1)));

    // R2: the reference rises only after the count has been zero
    a_r2_ref_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $rose(ref_q)) |-> ($past(cnt_q) == '0));
endmodule

// File: rtl/phref_channel.sv
// Module: phref_channel
// One delayed output. It holds a loaded word and applies it at the count
// wrap, then drives a registered square wave that is high while
// (count - word) mod 2^K lies in the first half of the range.
// Assumes cnt_i and wrap_i come from the shared time base.
module phref_channel #(
    parameter int unsigned K = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [K-1:0] cnt_i,
    input  logic         wrap_i,
    input  logic         load_i,
    input  logic [K-1:0] word_i,
    output logic         out_o
);
    localparam logic [K-1:0] HALF = K'(1) << (K - 1);

    logic [K-1:0] held_q;
    logic [K-1:0] word_q;
    logic [K-1:0] diff;
    logic         out_q;
    logic         armed_q;

    assign diff = cnt_i - word_q;

    // Holding register: the last strobed word wins.
    always_ff @(posedge clk) begin
        if (!rst_n)      held_q <= '0;
        else if (load_i) held_q <= word_i;
    end

    // Applied word: updated only at the wrap; a load on that edge goes straight in.
    always_ff @(posedge clk) begin
        if (!rst_n)      word_q <= '0;
        else if (wrap_i) word_q <= load_i ? word_i : held_q;
    end

    // Registered comparator output.
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= (diff < HALF);
    end

    // Marks that at least one edge has run out of reset (checks only).
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assign out_o = out_q;

    // R5: the applied word is steady except across a wrap edge
    a_r5_hold_until_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$past(wrap_i)) |-> $stable(word_q));

    // R6: a load on the wrap edge is applied at once
    a_r6_load_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(wrap_i) && $past(load_i)) |-> (word_q == $past(word_i)));

    // R4: a rising edge comes at the count equal to the word, or at a wrap-time switch
    a_r4_rise_at_word: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $rose(out_q)) |->
            (($past(cnt_i) == $past(word_q)) || ($past(cnt_i) == '0)));
endmodule

// File: rtl/phref_gen.sv
// Module: phref_gen (top)
// Multichannel phase-shifted reference generator: one shared time base
// feeds NCH channel comparators. Channel c takes phase_words[c*K +: K].
// Assumes K >= 2 and NCH >= 1.
module phref_gen
    import phref_pkg::*;
#(
    parameter int unsigned K   = PHREF_K_DEFAULT,
    parameter int unsigned NCH = PHREF_CH_DEFAULT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             word_load,
    input  logic [NCH*K-1:0] phase_words,
    output logic             ref_out,
    output logic [NCH-1:0]   chan_out
);
    logic [K-1:0] cnt;
    logic         wrap;

    // Shared count, wrap flag and undelayed reference.
    phref_timebase #(.K(K)) u_tb (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_o  (cnt),
        .wrap_o (wrap),
        .ref_o  (ref_out)
    );

    // One comparator channel per delayed output.
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        phref_channel #(.K(K)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .cnt_i  (cnt),
            .wrap_i (wrap),
            .load_i (word_load),
            .word_i (phase_words[c*K +: K]),
            .out_o  (chan_out[c])
        );
    end
endmodule

// File: tb/sim_phref_gen.sv
module sim_phref_gen;
    localparam int K   = 4;
    localparam int NCH = 4;
    localparam int N   = 1 << K;
    localparam logic [K-1:0] HALF = K'(1) << (K - 1);
    localparam logic [K-1:0] TOPV = '1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             word_load = 1'b0;
    logic [NCH*K-1:0] phase_words = '0;
    logic             ref_out;
    logic [NCH-1:0]   chan_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ref_rise = 0;
    int quiet = 0;
    bit chk_en = 1'b0;
    bit done = 1'b0;
    string phase_tag = "R3";

    // behavioural model state
    logic [K-1:0] m_cnt = '0;
    logic [K-1:0] m_held [NCH];
    logic [K-1:0] m_act  [NCH];
    logic [K-1:0] nv;
    logic [K-1:0] d;
    logic         e_ref = 1'b0;
    logic [NCH-1:0] e_out = '0;
    logic         prev_ref = 1'b0;
    logic [NCH-1:0] prev_ch = '0;
    bit changed;
    int nw [NCH];

    phref_gen #(.K(K), .NCH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .word_load(word_load),
        .phase_words(phase_words), .ref_out(ref_out), .chan_out(chan_out)
    );

    always #4 clk = ~clk;  // 125 MHz

    // Reference model: update on every rising edge from the inputs seen there.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = '0; e_ref = 1'b0; e_out = '0; quiet = 0;
            for (int c = 0; c < NCH; c++) begin m_held[c] = '0; m_act[c] = '0; end
        end else begin
            e_ref = (m_cnt < HALF);
            for (int c = 0; c < NCH; c++) begin
                d = m_cnt - m_act[c];
                e_out[c] = (d < HALF);
            end
            changed = 1'b0;
            if (m_cnt == TOPV) begin
                for (int c = 0; c < NCH; c++) begin
                    nv = word_load ? phase_words[c*K +: K] : m_held[c];
                    if (nv != m_act[c]) changed = 1'b1;
                    m_act[c] = nv;
                end
            end
            if (word_load)
                for (int c = 0; c < NCH; c++) m_held[c] = phase_words[c*K +: K];
            quiet = changed ? 0 : quiet + 1;
            m_cnt = m_cnt + 1'b1;
        end
        chk_en = 1'b1;
    end

    // Compare every output each cycle, and measure rising-edge offsets.
    always @(negedge clk) begin
        if (chk_en && !done) begin
            checks++;
            if (ref_out !== e_ref) begin
                errors++;
                $display("FAIL %s ref_out cycle %0d: got %b expected %b",
                         rst_n ? "R2" : "R1", cyc, ref_out, e_ref);
            end
            for (int c = 0; c < NCH; c++) begin
                checks++;
                if (chan_out[c] !== e_out[c]) begin
                    errors++;
                    $display("FAIL %s chan %0d cycle %0d: got %b expected %b",
                             rst_n ? phase_tag : "R1", c, cyc, chan_out[c], e_out[c]);
                end
            end
            if (ref_out && !prev_ref) ref_rise = cyc;
            for (int c = 0; c < NCH; c++) begin
                if (rst_n && chan_out[c] && !prev_ch[c] && quiet >= 2 * N) begin
                    checks++;  // R4 offset check
                    if (((cyc - ref_rise) % N) != int'(m_act[c])) begin
                        errors++;
                        $display("FAIL R4 chan %0d offset: got %0d expected %0d",
                                 c, (cyc - ref_rise) % N, m_act[c]);
                    end
                end
            end
        end
        prev_ref = ref_out;
        prev_ch  = chan_out;
        cyc++;
    end

    task automatic wait_cnt(input int v);
        while (int'(m_cnt) != v) @(negedge clk);
    endtask

    // Drive the words and a one-cycle strobe from the current negedge.
    task automatic load_now();
        for (int c = 0; c < NCH; c++) phase_words[c*K +: K] = nw[c][K-1:0];
        word_load = 1'b1;
        @(negedge clk);
        word_load = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);   // R1: outputs held low in reset
        rst_n = 1'b1;
        repeat (3 * N) @(negedge clk);

        // R3/R4: sweep every code, including 0 and 2^K-1, on channels 0 and 1
        for (int b = 0; b < N; b++) begin
            phase_tag = "R3";
            nw[0] = b; nw[1] = N - 1 - b; nw[2] = (b * 5) % N; nw[3] = (b + N / 2) % N;
            wait_cnt(3);
            load_now();
            repeat (4 * N) @(negedge clk);
        end

        // R5: two loads inside one period, last one wins, applied at wrap only
        phase_tag = "R5";
        nw[0] = 9; nw[1] = 2; nw[2] = 14; nw[3] = 5;
        wait_cnt(2); load_now();
        nw[0] = 6; nw[1] = 11; nw[2] = 1; nw[3] = 15;
        wait_cnt(6); load_now();
        repeat (3 * N) @(negedge clk);

        // R5: load just after a wrap waits almost a full period
        nw[0] = 13; nw[1] = 0; nw[2] = 7; nw[3] = 3;
        wait_cnt(0); load_now();
        repeat (3 * N) @(negedge clk);

        // R6: load coinciding with the wrap edge takes effect there
        phase_tag = "R6";
        nw[0] = 1; nw[1] = 15; nw[2] = 8; nw[3] = 0;
        wait_cnt(N - 1); load_now();
        repeat (3 * N) @(negedge clk);
        nw[0] = 12; nw[1] = 4; nw[2] = 10; nw[3] = 6;
        wait_cnt(N - 1); load_now();
        repeat (3 * N) @(negedge clk);

        // R1: reset in mid-run clears outputs and words
        phase_tag = "R3";
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3 * N) @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        errors++;
        done = 1'b1;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule